// File: doc/BRIEF.md
# PCI Bridge Error Logging Unit

This block gathers error events from both sides of a PCI host bridge: the side that starts transactions on the bus and the side that answers them. It keeps sticky status bits, decides whether to drive the active-low parity-error and system-error pins, and raises an interrupt request and a hard-fail response request toward the host side. The bus state machines upstream detect the events. Each event reaches this block as a single-cycle strobe. The block then sorts each event by bus role and command type.

Not every event counts as an error. A master abort on a Special Cycle is expected and is dropped. Retries and disconnects are not errors, so they never reach this block. The system-error pin needs a global enable and a per-cause enable together. The parity-error pin needs two enables as well. Read and write parity errors seen by the master side are logged in separate error-status bits. Software clears status bits by writing ones to them.

Top module: `pci_err_logger`

## Requirements
- R1: A master abort with the special-cycle flag clear sets status bit 13 one clock later. A master abort with the flag set changes no status bit and drives no output.
- R2: A master abort that is logged pulses `irqReq` for one clock, one clock later, when `intEn` is 1.
- R3: A received target abort sets status bit 12. It pulls `serrN` low only when `cmdSerrEn` and `ecmdSerrOnTgtAbort` are both 1.
- R4: In every clock in which `serrN` is low, status bit 14 is also set, starting in that same clock.
- R5: A received target abort pulses `hardFailReq` only when `hardFailEn` is 1 and `postedWr` is 0.
- R6: Any data parity error (master read, write-side parity error seen by the master, or target write) sets status bit 15. A master write error also sets error-status bit 6. A master read error also sets error-status bit 5. A target write error sets no error-status bit.
- R7: A master read parity error or a target write parity error pulls `perrN` low only when `cmdParRespEn` and `perrDriveEn` are both 1. A write-side parity error seen by the master never drives `perrN`.
- R8: A master read or master write parity error pulls `serrN` low only when `cmdSerrEn` and `ecmdSerrOnParity` are both 1.
- R9: A target abort signaled by the bridge sets status bit 11 and nothing else.
- R10: Status and error-status bits are sticky. A write with `stsClrWe` or `errClrWe` clears each bit whose data bit is 1. If a set and a clear hit the same bit in the same clock, the set wins. Unimplemented bits read 0.
- R11: After reset, all status bits are 0, `perrN` and `serrN` are 1, and `irqReq` and `hardFailReq` are 0.
- R12: `perrN`, `serrN`, `irqReq` and `hardFailReq` are registered. Each is active for exactly the one clock after the clock of its causing event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mstAbortEv | input | 1 | Master abort strobe |
| mstAbortSpecial | input | 1 | The aborted command was a Special Cycle |
| rcvTgtAbortEv | input | 1 | Target abort received as master |
| sigTgtAbortEv | input | 1 | Target abort signaled as target |
| mstRdParEv | input | 1 | Parity error on master read data |
| mstWrPerrEv | input | 1 | Parity error pin seen during master write |
| tgtWrParEv | input | 1 | Parity error on target write data |
| postedWr | input | 1 | Current master transaction is a posted write |
| cmdSerrEn | input | 1 | Command register system-error enable |
| cmdParRespEn | input | 1 | Command register parity response enable |
| perrDriveEn | input | 1 | Parity-error pin drive enable |
| ecmdSerrOnTgtAbort | input | 1 | System error on received target abort enable |
| ecmdSerrOnParity | input | 1 | System error on master parity error enable |
| intEn | input | 1 | Master abort interrupt enable |
| hardFailEn | input | 1 | Hard-fail response enable |
| stsClrWe | input | 1 | Status write-one-to-clear strobe |
| stsClrData | input | 16 | Status clear mask |
| errClrWe | input | 1 | Error-status write-one-to-clear strobe |
| errClrData | input | 8 | Error-status clear mask |
| stsBits | output | 16 | Status word (bits 11..15 implemented) |
| errStsBits | output | 8 | Error-status word (bits 5, 6 implemented) |
| perrN | output | 1 | Parity error pin, active low |
| serrN | output | 1 | System error pin, active low |
| irqReq | output | 1 | Interrupt request pulse |
| hardFailReq | output | 1 | Hard-fail response request pulse |

## Verification
If the event decode or a gating term is wrong, the fault shows at the ports one clock after the offending strobe: a status bit set or missing, or a pin pulse present or absent. The bench checks every output on every clock, so the fault is caught within one cycle. A fault in the sticky or clear path shows as a bit that drops without a clear write or that survives one. It appears on the next clock and stays visible until the next compare against the model.

// File: rtl/pci_err_pkg.sv
package pci_err_pkg;
  localparam int STS_SIG_TABORT = 11;
  localparam int STS_RCV_TABORT = 12;
  localparam int STS_RCV_MABORT = 13;
  localparam int STS_SIG_SERR   = 14;
  localparam int STS_PAR_DET    = 15;
  localparam int ERR_RD_PAR     = 5;
  localparam int ERR_WR_PAR     = 6;

  typedef struct packed {
    logic setSigTa;
    logic setRcvTa;
    logic setMa;
    logic setSse;
    logic setDpe;
    logic setWrPe;
    logic setRdPe;
    logic firePerr;
    logic fireSerr;
    logic fireIrq;
    logic fireHardFail;
  } ctlStrobes_t;
endpackage

// File: rtl/pci_err_ctl.sv
module pci_err_ctl
  import pci_err_pkg::*;
(
  input  logic        mstAbortEv,
  input  logic        mstAbortSpecial,
  input  logic        rcvTgtAbortEv,
  input  logic        sigTgtAbortEv,
  input  logic        mstRdParEv,
  input  logic        mstWrPerrEv,
  input  logic        tgtWrParEv,
  input  logic        postedWr,
  input  logic        cmdSerrEn,
  input  logic        cmdParRespEn,
  input  logic        perrDriveEn,
  input  logic        ecmdSerrOnTgtAbort,
  input  logic        ecmdSerrOnParity,
  input  logic        intEn,
  input  logic        hardFailEn,
  output ctlStrobes_t strobes
);
  logic maLogged;
  logic serrFromTa;
  logic serrFromPar;
  logic mstParAny;

  always_comb begin
    // Special-cycle aborts are expected and filtered out here
    maLogged    = mstAbortEv && !mstAbortSpecial;
    mstParAny   = mstRdParEv || mstWrPerrEv;
    serrFromTa  = rcvTgtAbortEv && cmdSerrEn && ecmdSerrOnTgtAbort;
    serrFromPar = mstParAny && cmdSerrEn && ecmdSerrOnParity;

    strobes              = '0;
    strobes.setSigTa     = sigTgtAbortEv;
    strobes.setRcvTa     = rcvTgtAbortEv;
    strobes.setMa        = maLogged;
    strobes.fireSerr     = serrFromTa || serrFromPar;
    strobes.setSse       = serrFromTa || serrFromPar;
    strobes.setDpe       = mstParAny || tgtWrParEv;
    strobes.setWrPe      = mstWrPerrEv;
    strobes.setRdPe      = mstRdParEv;
    // Only the side that checked the data drives the parity-error pin
    strobes.firePerr     = (mstRdParEv || tgtWrParEv) && cmdParRespEn && perrDriveEn;
    strobes.fireIrq      = maLogged && intEn;
    // A posted write has already finished its response phase
    strobes.fireHardFail = rcvTgtAbortEv && hardFailEn && !postedWr;
  end
endmodule

// File: rtl/pci_err_dp.sv
module pci_err_dp
  import pci_err_pkg::*;
#(
  parameter int STS_W = 16,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobes_t      strobes,
  input  logic             stsClrWe,
  input  logic [STS_W-1:0] stsClrData,
  input  logic             errClrWe,
  input  logic [ERR_W-1:0] errClrData,
  output logic [STS_W-1:0] stsBits,
  output logic [ERR_W-1:0] errStsBits,
  output logic             perrN,
  output logic             serrN,
  output logic             irqReq,
  output logic             hardFailReq
);
  localparam logic [STS_W-1:0] STS_IMPL =
    (STS_W'(1) << STS_SIG_TABORT) | (STS_W'(1) << STS_RCV_TABORT) |
    (STS_W'(1) << STS_RCV_MABORT) | (STS_W'(1) << STS_SIG_SERR) |
    (STS_W'(1) << STS_PAR_DET);
  localparam logic [ERR_W-1:0] ERR_IMPL =
    (ERR_W'(1) << ERR_RD_PAR) | (ERR_W'(1) << ERR_WR_PAR);

  logic [STS_W-1:0] stsQ, stsSet, stsClr;
  logic [ERR_W-1:0] errQ, errSet, errClr;

  always_comb begin
    stsSet = '0;
    stsSet[STS_SIG_TABORT] = strobes.setSigTa;
    stsSet[STS_RCV_TABORT] = strobes.setRcvTa;
    stsSet[STS_RCV_MABORT] = strobes.setMa;
    stsSet[STS_SIG_SERR]   = strobes.setSse;
    stsSet[STS_PAR_DET]    = strobes.setDpe;
    errSet = '0;
    errSet[ERR_RD_PAR] = strobes.setRdPe;
    errSet[ERR_WR_PAR] = strobes.setWrPe;
    stsClr = stsClrWe ? stsClrData : '0;
    errClr = errClrWe ? errClrData : '0;
  end

  // Sticky bits: clear first, then OR in sets so a set wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stsQ <= '0;
      errQ <= '0;
    end else begin
      stsQ <= ((stsQ & ~stsClr) | stsSet) & STS_IMPL;
      errQ <= ((errQ & ~errClr) | errSet) & ERR_IMPL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perrN       <= 1'b1;
      serrN       <= 1'b1;
      irqReq      <= 1'b0;
      hardFailReq <= 1'b0;
    end else begin
      perrN       <= !strobes.firePerr;
      serrN       <= !strobes.fireSerr;
      irqReq      <= strobes.fireIrq;
      hardFailReq <= strobes.fireHardFail;
    end
  end

  assign stsBits    = stsQ;
  assign errStsBits = errQ;
endmodule

// File: rtl/pci_err_logger.sv
module pci_err_logger
  import pci_err_pkg::*;
#(
  parameter int STS_W = 16,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mstAbortEv,
  input  logic             mstAbortSpecial,
  input  logic             rcvTgtAbortEv,
  input  logic             sigTgtAbortEv,
  input  logic             mstRdParEv,
  input  logic             mstWrPerrEv,
  input  logic             tgtWrParEv,
  input  logic             postedWr,
  input  logic             cmdSerrEn,
  input  logic             cmdParRespEn,
  input  logic             perrDriveEn,
  input  logic             ecmdSerrOnTgtAbort,
  input  logic             ecmdSerrOnParity,
  input  logic             intEn,
  input  logic             hardFailEn,
  input  logic             stsClrWe,
  input  logic [STS_W-1:0] stsClrData,
  input  logic             errClrWe,
  input  logic [ERR_W-1:0] errClrData,
  output logic [STS_W-1:0] stsBits,
  output logic [ERR_W-1:0] errStsBits,
  output logic             perrN,
  output logic             serrN,
  output logic             irqReq,
  output logic             hardFailReq
);
  ctlStrobes_t strobes;

  pci_err_ctl u_ctl (
    .mstAbortEv(mstAbortEv), .mstAbortSpecial(mstAbortSpecial),
    .rcvTgtAbortEv(rcvTgtAbortEv), .sigTgtAbortEv(sigTgtAbortEv),
    .mstRdParEv(mstRdParEv), .mstWrPerrEv(mstWrPerrEv),
    .tgtWrParEv(tgtWrParEv), .postedWr(postedWr),
    .cmdSerrEn(cmdSerrEn), .cmdParRespEn(cmdParRespEn),
    .perrDriveEn(perrDriveEn), .ecmdSerrOnTgtAbort(ecmdSerrOnTgtAbort),
    .ecmdSerrOnParity(ecmdSerrOnParity), .intEn(intEn),
    .hardFailEn(hardFailEn), .strobes(strobes)
  );

  pci_err_dp #(.STS_W(STS_W), .ERR_W(ERR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .stsClrWe(stsClrWe), .stsClrData(stsClrData),
    .errClrWe(errClrWe), .errClrData(errClrData),
    .stsBits(stsBits), .errStsBits(errStsBits),
    .perrN(perrN), .serrN(serrN), .irqReq(irqReq),
    .hardFailReq(hardFailReq)
  );
endmodule

// File: rtl/pci_err_logger_chk.sv
module pci_err_logger_chk #(
  parameter int STS_W = 16,
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mstAbortEv,
  input logic             mstAbortSpecial,
  input logic             rcvTgtAbortEv,
  input logic             sigTgtAbortEv,
  input logic             mstRdParEv,
  input logic             mstWrPerrEv,
  input logic             tgtWrParEv,
  input logic             postedWr,
  input logic             cmdSerrEn,
  input logic             cmdParRespEn,
  input logic             perrDriveEn,
  input logic             ecmdSerrOnTgtAbort,
  input logic             ecmdSerrOnParity,
  input logic             intEn,
  input logic             hardFailEn,
  input logic             stsClrWe,
  input logic [STS_W-1:0] stsClrData,
  input logic             errClrWe,
  input logic [ERR_W-1:0] errClrData,
  input logic [STS_W-1:0] stsBits,
  input logic [ERR_W-1:0] errStsBits,
  input logic             perrN,
  input logic             serrN,
  input logic             irqReq,
  input logic             hardFailReq
);
  p_ma_logged_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mstAbortEv && !mstAbortSpecial) |=> stsBits[13]);
  p_ma_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stsBits[13]) |-> $past(mstAbortEv && !mstAbortSpecial));
  p_irq_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> $past(mstAbortEv && !mstAbortSpecial && intEn));
  p_serr_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !serrN |-> $past(cmdSerrEn));
  p_serr_sse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !serrN |-> stsBits[14]);
  p_hardfail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hardFailReq |-> $past(rcvTgtAbortEv && hardFailEn && !postedWr));
  p_par_det_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mstRdParEv || mstWrPerrEv || tgtWrParEv) |=> stsBits[15]);
  p_perr_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !perrN |-> $past(cmdParRespEn && perrDriveEn && (mstRdParEv || tgtWrParEv)));
  p_sta_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sigTgtAbortEv |=> stsBits[11]);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stsBits[15]) |-> $past(stsClrWe && stsClrData[15]));
endmodule

bind pci_err_logger pci_err_logger_chk #(.STS_W(STS_W), .ERR_W(ERR_W)) chk (.*);

// File: tb/tb_pci_err_logger.sv
`timescale 1ns/1ps
module tb_pci_err_logger;
  logic clk = 1'b0;
  logic rst_n;
  logic mstAbortEv, mstAbortSpecial, rcvTgtAbortEv, sigTgtAbortEv;
  logic mstRdParEv, mstWrPerrEv, tgtWrParEv, postedWr;
  logic cmdSerrEn, cmdParRespEn, perrDriveEn, ecmdSerrOnTgtAbort;
  logic ecmdSerrOnParity, intEn, hardFailEn, stsClrWe, errClrWe;
  logic [15:0] stsClrData;
  logic [7:0]  errClrData;
  logic [15:0] stsBits;
  logic [7:0]  errStsBits;
  logic perrN, serrN, irqReq, hardFailReq;

  int checks = 0;
  int failures = 0;
  logic [15:0] expSts;
  logic [7:0]  expErr;
  logic expPerrN, expSerrN, expIrq, expHf;

  always #10 clk = ~clk;

  pci_err_logger dut (.*);

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    mstAbortEv = 0; mstAbortSpecial = 0; rcvTgtAbortEv = 0; sigTgtAbortEv = 0;
    mstRdParEv = 0; mstWrPerrEv = 0; tgtWrParEv = 0; postedWr = 0;
    stsClrWe = 0; errClrWe = 0; stsClrData = '0; errClrData = '0;
  endtask

  // Reference model computed from the requirements
  function automatic void model();
    logic maLog, serr, perr;
    logic [15:0] sSet, sClr;
    logic [7:0]  eSet, eClr;
    maLog = mstAbortEv && !mstAbortSpecial;                       // R1
    serr  = (rcvTgtAbortEv && cmdSerrEn && ecmdSerrOnTgtAbort) ||   // R3
            ((mstRdParEv || mstWrPerrEv) && cmdSerrEn && ecmdSerrOnParity); // R8
    perr  = (mstRdParEv || tgtWrParEv) && cmdParRespEn && perrDriveEn; // R7
    sSet = '0;
    sSet[11] = sigTgtAbortEv;                                     // R9
    sSet[12] = rcvTgtAbortEv;
    sSet[13] = maLog;
    sSet[14] = serr;                                              // R4
    sSet[15] = mstRdParEv || mstWrPerrEv || tgtWrParEv;           // R6
    eSet = '0;
    eSet[5] = mstRdParEv;
    eSet[6] = mstWrPerrEv;
    sClr = stsClrWe ? stsClrData : '0;
    eClr = errClrWe ? errClrData : '0;
    expSts = (expSts & ~sClr) | sSet;                             // R10
    expErr = (expErr & ~eClr) | eSet;
    expPerrN = !perr;
    expSerrN = !serr;
    expIrq = maLog && intEn;                                      // R2
    expHf = rcvTgtAbortEv && hardFailEn && !postedWr;             // R5
  endfunction

  task automatic compareAll(input string ctx);
    check(stsBits === expSts, {"R1 R3 R6 R9 R10 status ", ctx}, stsBits, expSts);
    check(errStsBits === expErr, {"R6 R10 errstatus ", ctx}, 16'(errStsBits), 16'(expErr));
    check(perrN === expPerrN, {"R7 R12 perrN ", ctx}, 16'(perrN), 16'(expPerrN));
    check(serrN === expSerrN, {"R3 R8 R12 serrN ", ctx}, 16'(serrN), 16'(expSerrN));
    check(irqReq === expIrq, {"R2 R12 irqReq ", ctx}, 16'(irqReq), 16'(expIrq));
    check(hardFailReq === expHf, {"R5 R12 hardFailReq ", ctx}, 16'(hardFailReq), 16'(expHf));
  endtask

  // Inputs are already set at a negedge; advance one edge and compare
  task automatic step(input string ctx);
    @(posedge clk);
    model();
    @(negedge clk);
    compareAll(ctx);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    logic v;
    seed = 32'h1c5a;
    v = $urandom(seed);
    idle();
    cmdSerrEn = 1; cmdParRespEn = 1; perrDriveEn = 1; ecmdSerrOnTgtAbort = 1;
    ecmdSerrOnParity = 1; intEn = 1; hardFailEn = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    expSts = '0; expErr = '0; expPerrN = 1; expSerrN = 1; expIrq = 0; expHf = 0;
    compareAll("R11 reset");

    // R1: special-cycle abort is silent
    mstAbortEv = 1; mstAbortSpecial = 1; step("R1 special");
    idle(); step("R1 special after");
    check(stsBits[13] === 1'b0, "R1 special not logged", stsBits, 16'h0);
    // R1 R2: normal abort is logged, irq pulses for one clock
    mstAbortEv = 1; step("R2 ma");
    idle(); step("R12 ma next");
    check(irqReq === 1'b0, "R12 irq single clock", 16'(irqReq), 16'h0);
    // R3 R5: received target abort, posted then not posted
    rcvTgtAbortEv = 1; postedWr = 1; step("R5 posted");
    idle(); rcvTgtAbortEv = 1; step("R5 nonposted");
    // R3: only one of the two enables
    idle(); ecmdSerrOnTgtAbort = 0; rcvTgtAbortEv = 1; step("R3 one enable");
    check(serrN === 1'b1, "R3 serr gated", 16'(serrN), 16'h1);
    ecmdSerrOnTgtAbort = 1;
    // R6 R7 R8: parity classes
    idle(); mstWrPerrEv = 1; step("R6 mst write");
    check(perrN === 1'b1, "R7 no perr on seen write error", 16'(perrN), 16'h1);
    idle(); mstRdParEv = 1; step("R6 mst read");
    idle(); stsClrWe = 1; stsClrData = 16'hffff; errClrWe = 1; errClrData = 8'hff; step("R10 clear all");
    idle(); tgtWrParEv = 1; step("R6 tgt write");
    check(errStsBits === 8'h00, "R6 tgt write no errstatus", 16'(errStsBits), 16'h0);
    idle(); cmdParRespEn = 0; mstRdParEv = 1; step("R7 gated");
    cmdParRespEn = 1;
    // R9: signaled target abort only sets bit 11
    idle(); stsClrWe = 1; stsClrData = 16'hffff; step("R10 clear");
    idle(); sigTgtAbortEv = 1; step("R9 sta");
    check(stsBits === 16'h0800, "R9 only bit 11", stsBits, 16'h0800);
    // R10: set wins over clear in the same clock
    idle(); sigTgtAbortEv = 1; stsClrWe = 1; stsClrData = 16'h0800; step("R10 set wins");
    check(stsBits[11] === 1'b1, "R10 set beats clear", stsBits, 16'h0800);
    idle(); step("R10 sticky hold");

    // Constrained random phase
    for (int i = 0; i < 3000; i++) begin
      idle();
      mstAbortEv = ($urandom % 6) == 0; mstAbortSpecial = $urandom % 2;
      rcvTgtAbortEv = ($urandom % 7) == 0; sigTgtAbortEv = ($urandom % 7) == 0;
      mstRdParEv = ($urandom % 8) == 0; mstWrPerrEv = ($urandom % 8) == 0;
      tgtWrParEv = ($urandom % 8) == 0; postedWr = $urandom % 2;
      cmdSerrEn = ($urandom % 4) != 0; cmdParRespEn = ($urandom % 4) != 0;
      perrDriveEn = ($urandom % 4) != 0; ecmdSerrOnTgtAbort = $urandom % 2;
      ecmdSerrOnParity = $urandom % 2; intEn = $urandom % 2; hardFailEn = $urandom % 2;
      stsClrWe = ($urandom % 6) == 0; stsClrData = 16'($urandom);
      errClrWe = ($urandom % 6) == 0; errClrData = 8'($urandom);
      step("random");
    end
    idle(); step("R12 drain");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule